// File: doc/BRIEF.md
# Table-Driven Candidate Output Router

This block decides which output channels a header flit may take at one mesh router. The current and destination coordinates give an offset. The offset is clamped to a square observation window of WIN by WIN routers centred on the current router. The clamped offset indexes a local table of per-direction path counts. Each direction is kept only if four things hold: its count is nonzero, its link is healthy, it stays inside the mesh, and the odd-even turn restriction allows it for the direction the flit arrived travelling in.

Minimal directions are preferred. If none of them survives, the block falls back to the surviving non-minimal directions and flags the result as a detour. A destination beyond the window is handled by the same clamp. The lookup then uses the furthest in-window router lying in the same direction, and the packet is steered toward that router. Because the decision is repeated at every hop, routing resolves exactly once the destination comes within the window.

The count table is loaded through a simple write port while the network warms up. The result is a registered 4-bit candidate mask. Selection among the candidates is left to a later stage.

Top module: `rt_cand_route`

## Requirements
- R1: While reset is held and right after it, cand_valid, cand_mask and cand_detour are all 0.
- R2: cand_valid is 1 in exactly the cycle after a cycle with hdr_valid high, and 0 otherwise. cand_mask and cand_detour keep their last values between headers.
- R3: Direction codes and mask bits are: bit0 North (+y), bit1 East (+x), bit2 South (-y), bit3 West (-x). A direction is minimal when it reduces the clamped offset. When at least one minimal direction survives filtering, cand_mask holds exactly the surviving minimal directions and cand_detour is 0.
- R4: A direction whose table count is zero, or whose link_fault bit is 1, never appears in cand_mask.
- R5: When no minimal direction survives, cand_mask holds exactly the surviving non-minimal directions and cand_detour is 1.
- R6: Turn rules depend on in_travel, the direction of arrival: 0 N, 1 E, 2 S, 3 W, 4 injected locally. A flit travelling East at an even column may not go North or South. A flit travelling North or South at an odd column may not go West. No flit may reverse its travel direction.
- R7: No direction that would leave the MESH_K by MESH_K mesh is offered. North is barred at y = MESH_K-1, East at x = MESH_K-1, South at y = 0 and West at x = 0.
- R8: Each offset component (destination minus current) is clamped to ±(WIN-1)/2 before both the table lookup and the minimal-direction decision.
- R9: A write with tbl_we sets the count at window column tbl_wx and window row tbl_wy for direction tbl_dir. The window coordinate is the offset plus (WIN-1)/2. Writes to the centre position are ignored. A written count is used by any header presented in a later cycle.
- R10: A header whose destination equals the current router yields cand_mask 0 and cand_detour 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Count table write strobe |
| tbl_wx | input | WW | Window column of the written entry |
| tbl_wy | input | WW | Window row of the written entry |
| tbl_dir | input | 2 | Direction of the written entry |
| tbl_cnt | input | CW | Path count to store |
| hdr_valid | input | 1 | Header flit present this cycle |
| cur_x | input | CBW | Current router column |
| cur_y | input | CBW | Current router row |
| dst_x | input | CBW | Destination column |
| dst_y | input | CBW | Destination row |
| in_travel | input | 3 | Direction the flit arrived travelling in |
| link_fault | input | 4 | Per-direction faulty-link flags |
| cand_valid | output | 1 | Candidate mask updated this cycle |
| cand_mask | output | 4 | Candidate output channels |
| cand_detour | output | 1 | Mask holds non-minimal candidates |

## Verification
The mask and detour flag are computed combinationally from the header inputs and the table. They are captured on the rising edge that ends the header cycle, so they are due one cycle after hdr_valid. The bench drives each header on a falling edge and reads the outputs on the next falling edge. A table write takes effect on the edge that ends its cycle. Every header is therefore presented at least one full cycle after the writes it depends on, and the bench's own copy of the table is updated at that point. One cycle after each header, the bench also confirms that cand_valid has dropped and that the mask is still held.

// File: rtl/rt_pkg.sv
package rt_pkg;

  localparam int NDIR = 4;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_E = 2'd1,
    DIR_S = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  localparam logic [2:0] TRAVEL_LOCAL = 3'd4;

  // Limit one offset component to the window radius.
  function automatic int clamp_off(input int v, input int r);
    if (v > r) return r;
    if (v < -r) return -r;
    return v;
  endfunction

  // Position slot inside the window, with the centre removed from the numbering.
  function automatic int win_slot(input int ox, input int oy, input int r);
    int w;
    int p;
    int c;
    w = 2 * r + 1;
    p = (oy + r) * w + (ox + r);
    c = r * w + r;
    return (p > c) ? p - 1 : p;
  endfunction

  // Directions the odd-even turn model and the no-reversal rule allow.
  function automatic logic [3:0] turn_ok(input logic [2:0] travel, input logic col_odd);
    logic [3:0] m;
    m = 4'b1111;
    if (!travel[2]) begin
      m[travel[1:0] ^ 2'b10] = 1'b0;
      if (travel[1:0] == DIR_E && !col_odd) begin
        m[DIR_N] = 1'b0;
        m[DIR_S] = 1'b0;
      end
      if ((travel[1:0] == DIR_N || travel[1:0] == DIR_S) && col_odd)
        m[DIR_W] = 1'b0;
    end
    return m;
  endfunction

  // Directions that shrink a (clamped) offset.
  function automatic logic [3:0] min_dirs(input int ox, input int oy);
    logic [3:0] m;
    m = 4'b0000;
    m[DIR_N] = (oy > 0);
    m[DIR_E] = (ox > 0);
    m[DIR_S] = (oy < 0);
    m[DIR_W] = (ox < 0);
    return m;
  endfunction

endpackage

// File: rtl/rt_win_map.sv
module rt_win_map
  import rt_pkg::*;
#(
  parameter int MESH_K = 8,
  parameter int WIN    = 5,
  localparam int CBW   = $clog2(MESH_K),
  localparam int OW    = $clog2((WIN - 1) / 2 + 1) + 1
) (
  input  logic [CBW-1:0]       cur_x,
  input  logic [CBW-1:0]       cur_y,
  input  logic [CBW-1:0]       dst_x,
  input  logic [CBW-1:0]       dst_y,
  output logic signed [OW-1:0] ox,
  output logic signed [OW-1:0] oy,
  output logic [3:0]           min_mask,
  output logic [3:0]           edge_ok,
  output logic                 at_dest
);

  localparam int RAD = (WIN - 1) / 2;

  int dx_c;
  int dy_c;

  always_comb begin
    dx_c     = clamp_off(int'(dst_x) - int'(cur_x), RAD);
    dy_c     = clamp_off(int'(dst_y) - int'(cur_y), RAD);
    ox       = OW'(dx_c);
    oy       = OW'(dy_c);
    min_mask = min_dirs(dx_c, dy_c);
    at_dest  = (dx_c == 0) && (dy_c == 0);
    edge_ok[DIR_N] = (cur_y != CBW'(MESH_K - 1));
    edge_ok[DIR_E] = (cur_x != CBW'(MESH_K - 1));
    edge_ok[DIR_S] = (cur_y != '0);
    edge_ok[DIR_W] = (cur_x != '0);
  end

endmodule

// File: rtl/rt_count_tbl.sv
module rt_count_tbl
  import rt_pkg::*;
#(
  parameter int WIN  = 5,
  parameter int CW   = 4,
  localparam int WW  = $clog2(WIN),
  localparam int OW  = $clog2((WIN - 1) / 2 + 1) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [WW-1:0]          wx,
  input  logic [WW-1:0]          wy,
  input  logic [1:0]             wdir,
  input  logic [CW-1:0]          wcnt,
  input  logic signed [OW-1:0]   rd_ox,
  input  logic signed [OW-1:0]   rd_oy,
  output logic [NDIR-1:0][CW-1:0] rd_cnt
);

  localparam int RAD   = (WIN - 1) / 2;
  localparam int SLOTS = WIN * WIN - 1;
  localparam int ENT   = SLOTS * NDIR;
  localparam int IW    = $clog2(ENT);

  logic [CW-1:0] mem [ENT];

  logic          w_hit;
  logic [IW-1:0] w_idx;
  int            w_slot;
  int            r_slot;
  logic          r_center;

  always_comb begin
    w_hit  = we && (int'(wx) < WIN) && (int'(wy) < WIN) &&
             !((int'(wx) == RAD) && (int'(wy) == RAD));
    w_slot = win_slot(int'(wx) - RAD, int'(wy) - RAD, RAD);
    w_idx  = IW'(w_slot * NDIR + int'(wdir));
    r_slot   = win_slot(int'(rd_ox), int'(rd_oy), RAD);
    r_center = (rd_ox == '0) && (rd_oy == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) mem[i] <= '0;
    end else if (w_hit) begin
      mem[w_idx] <= wcnt;
    end
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_rd
    assign rd_cnt[d] = r_center ? '0 : mem[IW'(r_slot * NDIR + d)];
  end

endmodule

// File: rtl/rt_cand_filter.sv
module rt_cand_filter
  import rt_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [NDIR-1:0][CW-1:0] cnt,
  input  logic [3:0]              min_mask,
  input  logic [3:0]              edge_ok,
  input  logic [3:0]              link_fault,
  input  logic                    at_dest,
  input  logic [2:0]              travel,
  input  logic                    col_odd,
  output logic [3:0]              mask,
  output logic                    detour
);

  logic [3:0] nz;
  logic [3:0] usable;
  logic [3:0] min_keep;
  logic [3:0] alt_keep;

  for (genvar d = 0; d < NDIR; d++) begin : g_nz
    assign nz[d] = (cnt[d] != '0);
  end

  always_comb begin
    usable   = nz & ~link_fault & edge_ok & turn_ok(travel, col_odd);
    min_keep = usable & min_mask;
    alt_keep = usable & ~min_mask;
    if (at_dest) begin
      mask   = 4'b0000;
      detour = 1'b0;
    end else if (min_keep != 4'b0000) begin
      mask   = min_keep;
      detour = 1'b0;
    end else begin
      mask   = alt_keep;
      detour = 1'b1;
    end
  end

endmodule

// File: rtl/rt_cand_route.sv
module rt_cand_route
  import rt_pkg::*;
#(
  parameter int MESH_K = 8,
  parameter int WIN    = 5,
  parameter int CW     = 4,
  localparam int CBW   = $clog2(MESH_K),
  localparam int WW    = $clog2(WIN),
  localparam int OW    = $clog2((WIN - 1) / 2 + 1) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tbl_we,
  input  logic [WW-1:0]  tbl_wx,
  input  logic [WW-1:0]  tbl_wy,
  input  logic [1:0]     tbl_dir,
  input  logic [CW-1:0]  tbl_cnt,
  input  logic           hdr_valid,
  input  logic [CBW-1:0] cur_x,
  input  logic [CBW-1:0] cur_y,
  input  logic [CBW-1:0] dst_x,
  input  logic [CBW-1:0] dst_y,
  input  logic [2:0]     in_travel,
  input  logic [3:0]     link_fault,
  output logic           cand_valid,
  output logic [3:0]     cand_mask,
  output logic           cand_detour
);

  logic signed [OW-1:0]   ox;
  logic signed [OW-1:0]   oy;
  logic [3:0]             min_mask;
  logic [3:0]             edge_ok;
  logic                   at_dest;
  logic [NDIR-1:0][CW-1:0] cnt;
  logic [3:0]             nxt_mask;
  logic                   nxt_detour;

  rt_win_map #(.MESH_K(MESH_K), .WIN(WIN)) u_map (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .ox(ox), .oy(oy), .min_mask(min_mask), .edge_ok(edge_ok), .at_dest(at_dest)
  );

  rt_count_tbl #(.WIN(WIN), .CW(CW)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .wx(tbl_wx), .wy(tbl_wy), .wdir(tbl_dir), .wcnt(tbl_cnt),
    .rd_ox(ox), .rd_oy(oy), .rd_cnt(cnt)
  );

  rt_cand_filter #(.CW(CW)) u_filt (
    .cnt(cnt), .min_mask(min_mask), .edge_ok(edge_ok), .link_fault(link_fault),
    .at_dest(at_dest), .travel(in_travel), .col_odd(cur_x[0]),
    .mask(nxt_mask), .detour(nxt_detour)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_valid  <= 1'b0;
      cand_mask   <= 4'b0000;
      cand_detour <= 1'b0;
    end else begin
      cand_valid <= hdr_valid;
      if (hdr_valid) begin
        cand_mask   <= nxt_mask;
        cand_detour <= nxt_detour;
      end
    end
  end

  // R2
  hdr_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> cand_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !cand_valid);

  // R4
  fault_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> ((cand_mask & $past(link_fault)) == 4'b0000));

  // R5
  detour_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !(cand_detour && ((cand_mask & $past(min_mask)) != 4'b0000)));

  // R6
  even_col_east_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && in_travel == {1'b0, DIR_E} && !cur_x[0]) |=>
      (!cand_mask[DIR_N] && !cand_mask[DIR_S]));

  // R7
  north_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cur_y == CBW'(MESH_K - 1)) |=> !cand_mask[DIR_N]);

  // R10
  at_dest_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && cur_x == dst_x && cur_y == dst_y) |=>
      (cand_mask == 4'b0000 && !cand_detour));

endmodule

// File: tb/rt_cand_route_tb.sv
`timescale 1ns/1ps
module rt_cand_route_tb;

  localparam int K   = 8;
  localparam int WIN = 5;
  localparam int CW  = 4;
  localparam int RD  = 2;

  logic       clk;
  logic       rst_n;
  logic       tbl_we;
  logic [2:0] tbl_wx;
  logic [2:0] tbl_wy;
  logic [1:0] tbl_dir;
  logic [3:0] tbl_cnt;
  logic       hdr_valid;
  logic [2:0] cur_x, cur_y, dst_x, dst_y;
  logic [2:0] in_travel;
  logic [3:0] link_fault;
  logic       cand_valid;
  logic [3:0] cand_mask;
  logic       cand_detour;

  int  tt [WIN][WIN][4];
  int  tests;
  int  fails;
  bit  done;
  int  seed_val;

  rt_cand_route #(.MESH_K(K), .WIN(WIN), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_wx(tbl_wx), .tbl_wy(tbl_wy), .tbl_dir(tbl_dir), .tbl_cnt(tbl_cnt),
    .hdr_valid(hdr_valid), .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .in_travel(in_travel), .link_fault(link_fault),
    .cand_valid(cand_valid), .cand_mask(cand_mask), .cand_detour(cand_detour)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim(input int v);
    if (v > RD) return RD;
    if (v < -RD) return -RD;
    return v;
  endfunction

  function automatic void model(input int cx, input int cy, input int dx, input int dy,
                                input int tr, input int flt, output int m, output int det);
    int ox, oy, mn, al;
    bit want, good;
    ox = lim(dx - cx);
    oy = lim(dy - cy);
    m = 0; det = 0; mn = 0; al = 0;
    if (ox == 0 && oy == 0) return;
    for (int d = 0; d < 4; d++) begin
      want = (d == 0 && oy > 0) || (d == 1 && ox > 0) || (d == 2 && oy < 0) || (d == 3 && ox < 0);
      good = (tt[oy + RD][ox + RD][d] != 0) && (((flt >> d) & 1) == 0);
      if (d == 0 && cy == K - 1) good = 0;
      if (d == 1 && cx == K - 1) good = 0;
      if (d == 2 && cy == 0) good = 0;
      if (d == 3 && cx == 0) good = 0;
      if (tr < 4) begin
        if (d == (tr + 2) % 4) good = 0;
        if (tr == 1 && (cx % 2) == 0 && (d == 0 || d == 2)) good = 0;
        if ((tr == 0 || tr == 2) && (cx % 2) == 1 && d == 3) good = 0;
      end
      if (good && want) mn |= (1 << d);
      if (good && !want) al |= (1 << d);
    end
    if (mn != 0) m = mn;
    else begin m = al; det = 1; end
  endfunction

  task automatic wr(input int wx, input int wy, input int d, input int c);
    @(negedge clk);
    tbl_we = 1'b1; tbl_wx = 3'(wx); tbl_wy = 3'(wy); tbl_dir = 2'(d); tbl_cnt = 4'(c);
    @(negedge clk);
    tbl_we = 1'b0;
    if (!(wx == RD && wy == RD)) tt[wy][wx][d] = c;
  endtask

  task automatic send(input string req, input int cx, input int cy, input int dx, input int dy,
                      input int tr, input int flt, input int hard_m, input int hard_d);
    int em, ed;
    @(negedge clk);
    hdr_valid = 1'b1;
    cur_x = 3'(cx); cur_y = 3'(cy); dst_x = 3'(dx); dst_y = 3'(dy);
    in_travel = 3'(tr); link_fault = 4'(flt);
    @(negedge clk);
    hdr_valid = 1'b0;
    model(cx, cy, dx, dy, tr, flt, em, ed);
    if (hard_m >= 0) begin
      chk({req, " directed mask"}, em, hard_m);
      chk({req, " directed detour"}, ed, hard_d);
    end
    chk({req, " R2 valid"}, int'(cand_valid), 1);
    chk({req, " mask"}, int'(cand_mask), em);
    chk({req, " detour"}, int'(cand_detour), ed);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int pm, pd;
    tests = 0; fails = 0; done = 0;
    seed_val = $urandom(32'h5eed1);
    rst_n = 1'b0; tbl_we = 1'b0; tbl_wx = '0; tbl_wy = '0; tbl_dir = '0; tbl_cnt = '0;
    hdr_valid = 1'b0; cur_x = '0; cur_y = '0; dst_x = '0; dst_y = '0;
    in_travel = 3'd4; link_fault = '0;
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++)
        for (int d = 0; d < 4; d++) tt[y][x][d] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 valid in reset", int'(cand_valid), 0);
    chk("R1 mask in reset", int'(cand_mask), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(cand_valid), 0);
    chk("R1 mask after reset", int'(cand_mask), 0);
    chk("R1 detour after reset", int'(cand_detour), 0);

    // R9: load the table with random counts, some zero; centre writes are dropped
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++)
        for (int d = 0; d < 4; d++)
          wr(x, y, d, (($urandom % 10) < 3) ? 0 : int'($urandom % 15) + 1);

    // R10: destination reached
    send("R10", 3, 3, 3, 3, 4, 0, 0, 0);

    // R8: far destination, clamped to window corner; East count zero leaves North
    wr(4, 4, 0, 5); wr(4, 4, 1, 0); wr(4, 4, 2, 3); wr(4, 4, 3, 3);
    send("R8 far clamp", 0, 0, 7, 7, 4, 0, 1, 0);

    // R5: sole minimal East has zero count -> detour N|S|W
    wr(4, 2, 0, 1); wr(4, 2, 1, 0); wr(4, 2, 2, 1); wr(4, 2, 3, 1);
    send("R5 detour", 2, 2, 4, 2, 4, 0, 13, 1);
    // R3: East restored, taken minimally
    wr(4, 2, 1, 7);
    send("R3 minimal", 2, 2, 4, 2, 4, 0, 2, 0);
    // R4: East link faulty -> detour
    send("R4 fault", 2, 2, 4, 2, 4, 2, 13, 1);
    // R2: one cycle later valid has dropped and the mask is held
    @(negedge clk);
    chk("R2 valid drops", int'(cand_valid), 0);
    chk("R2 mask held", int'(cand_mask), 13);

    // R6: travelling East at even column, North barred
    wr(3, 4, 0, 2); wr(3, 4, 1, 2); wr(3, 4, 2, 2); wr(3, 4, 3, 2);
    send("R6 even col", 2, 2, 3, 4, 1, 0, 2, 0);
    // R6: travelling North at odd column, West barred, South is a reversal
    wr(0, 2, 0, 2); wr(0, 2, 1, 2); wr(0, 2, 2, 2); wr(0, 2, 3, 2);
    send("R6 odd col", 3, 2, 1, 2, 0, 0, 3, 1);

    // R7: corner router, detour may not leave the mesh
    wr(2, 0, 0, 1); wr(2, 0, 1, 1); wr(2, 0, 2, 0); wr(2, 0, 3, 1);
    send("R7 edge", 7, 7, 7, 5, 4, 0, 8, 1);
    // R9: rewrite the South count and observe its effect
    wr(2, 0, 2, 4);
    send("R9 rewrite", 7, 7, 7, 5, 4, 0, 4, 0);

    // R3: random headers against the model
    for (int i = 0; i < 400; i++) begin
      send("R3 random", int'($urandom % K), int'($urandom % K), int'($urandom % K),
           int'($urandom % K), int'($urandom % 5), int'($urandom & $urandom & 15), -1, 0);
      if ((i % 7) == 0) begin
        pm = int'(cand_mask); pd = int'(cand_detour);
        @(negedge clk);
        chk("R2 random drop", int'(cand_valid), 0);
        chk("R2 random hold", int'(cand_mask), pm);
        chk("R2 random hold detour", int'(cand_detour), pd);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule